// File: doc/BRIEF.md
# Flag Offset Loader

This block fills the four programmable threshold registers that the flag logic of a two-FIFO buffer compares against. It runs once after each master reset, and its write order is fixed. The first value is the almost-full threshold of the first write port (Y1). The second is the almost-empty threshold of the second read port (X1). The third is the almost-full threshold of the second write port (Y2). The last is the almost-empty threshold of the first read port (X2). The input-ready flags of both write ports stay low until the last value has been stored, and then both rise together.

The load path is chosen while master reset is held. In parallel mode the loader takes one whole threshold from the write data bus on each qualified clock edge. In serial mode the two mode-select pins change function. `selEnN` becomes an active-low shift enable and `selData` becomes the serial data bit. In this mode the loader takes one bit per enabled edge, most significant bit first, for a total of 4×W bits. In either mode, idle cycles may fall between values or between bits, and they do not change the loader state. After loading is complete, the thresholds stay frozen until the next master reset.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrstN` is low, all four thresholds clear to 0, `loadDone`, `readyA` and `readyC` go low, and `loadIdx` returns to 0.
- R2: The mode is taken at the last clock edge with `mrstN` low. Parallel mode is selected when `selHi`=1, `selEnN`=0 and `selData`=0. Every other combination selects serial mode. Changing these pins after reset does not change the mode.
- R3: In parallel mode, a threshold is accepted on a rising edge only when `portEn`=1, `csN`=0, `wrSel`=1 and `mbSel`=0. Each of the other 15 combinations of these four pins leaves the loader unchanged.
- R4: Thresholds are stored in the order Y1, X1, Y2, X2, with `loadIdx` values 0, 1, 2, 3. `loadIdx` rises by one for each stored threshold. It holds at 3 once loading is done.
- R5: In serial mode, each edge with `selEnN`=0 shifts in the bit on `selData`. The most significant bit comes first. After every W bits the assembled word is written into the register selected by `loadIdx`, and that register keeps its old value until then.
- R6: A cycle in which the active load path is not enabled leaves `loadIdx`, the bit position and all thresholds unchanged.
- R7: `readyA` and `readyC` stay low until the fourth threshold is stored. On the edge that stores it, both flags rise together with `loadDone`.
- R8: Once `loadDone` is high, further activity on either load path leaves the four thresholds unchanged and keeps `loadDone` high until the next master reset.
- R9: The path that was not selected is ignored. Serial pins have no effect in parallel mode, and qualified parallel writes have no effect in serial mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-port clock |
| mrstN | input | 1 | Master reset, active low |
| selHi | input | 1 | Mode select, upper pin |
| selEnN | input | 1 | Mode select; serial shift enable (active low) in serial mode |
| selData | input | 1 | Mode select; serial data bit in serial mode |
| portEn | input | 1 | Write port enable |
| csN | input | 1 | Chip select, active low |
| wrSel | input | 1 | Write/read direction, high for write |
| mbSel | input | 1 | Mailbox select, must be low to load |
| busIn | input | W | Low W bits of the write data bus |
| offY1 | output | W | Almost-full threshold, first write port |
| offX1 | output | W | Almost-empty threshold, second read port |
| offY2 | output | W | Almost-full threshold, second write port |
| offX2 | output | W | Almost-empty threshold, first read port |
| readyA | output | 1 | Input-ready flag, first write port |
| readyC | output | 1 | Input-ready flag, second write port |
| loadDone | output | 1 | All four thresholds stored |
| loadIdx | output | 2 | Index of the threshold being loaded |

## Verification
Each fault in the internal state shows up at the ports, and the timing depends on the fault:
- A wrong latched mode becomes visible on the first qualified write after reset. Either `loadIdx` fails to advance, or a threshold fills from the wrong path.
- A slipped bit counter in serial mode is exposed within one word, as a threshold stored early or a value shifted by one position.
- A wrong word index puts a value into the wrong one of the four outputs on the same edge that stores it.
- A done state that is wrong shows as ready flags that rise too soon, or as thresholds that change after completion.

// File: rtl/fol_pkg.sv
package fol_pkg;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic       shift;   // take one serial bit
    logic       commit;  // write a complete word
    logic [1:0] idx;     // target register: 0=Y1 1=X1 2=Y2 3=X2
  } fol_strobe_t;

endpackage

// File: rtl/fol_ctrl.sv
module fol_ctrl
  import fol_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        mrstN,
  input  logic        selHi,
  input  logic        selEnN,
  input  logic        selData,
  input  logic        portEn,
  input  logic        csN,
  input  logic        wrSel,
  input  logic        mbSel,
  output fol_strobe_t strobe,
  output logic        modeSerial,
  output logic        done,
  output logic        rdyA,
  output logic        rdyC
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic [CNT_W-1:0] bitIdx;
  logic [1:0]       wordIdx;
  logic             serStep;
  logic             parTake;
  logic             lastBit;

  always_comb begin
    serStep       = modeSerial && !selEnN && !done;
    parTake       = !modeSerial && portEn && !csN && wrSel && !mbSel && !done;
    lastBit       = (bitIdx == LAST_BIT);
    strobe.shift  = serStep;
    strobe.commit = parTake || (serStep && lastBit);
    strobe.idx    = wordIdx;
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      modeSerial <= !(selHi && !selEnN && !selData);
      bitIdx     <= '0;
      wordIdx    <= '0;
      done       <= 1'b0;
      rdyA       <= 1'b0;
      rdyC       <= 1'b0;
    end else begin
      if (serStep) begin
        bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
      end
      if (strobe.commit) begin
        if (wordIdx == 2'd3) begin
          done <= 1'b1;
          rdyA <= 1'b1;
          rdyC <= 1'b1;
        end else begin
          wordIdx <= wordIdx + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/fol_datapath.sv
module fol_datapath
  import fol_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          mrstN,
  input  fol_strobe_t   strobe,
  input  logic          modeSerial,
  input  logic          serBit,
  input  logic [W-1:0]  busIn,
  output logic [W-1:0]  offReg [4]
);

  logic [W-2:0] shReg;
  logic [W-1:0] serWord;
  logic [W-1:0] newWord;

  always_comb begin
    serWord = {shReg, serBit};
    newWord = modeSerial ? serWord : busIn;
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      shReg <= '0;
    end else if (strobe.shift) begin
      shReg <= serWord[W-2:0];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_off
    always_ff @(posedge clk) begin
      if (!mrstN) begin
        offReg[g] <= '0;
      end else if (strobe.commit && (strobe.idx == 2'(g))) begin
        offReg[g] <= newWord;
      end
    end
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import fol_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          mrstN,
  input  logic          selHi,
  input  logic          selEnN,
  input  logic          selData,
  input  logic          portEn,
  input  logic          csN,
  input  logic          wrSel,
  input  logic          mbSel,
  input  logic [W-1:0]  busIn,
  output logic [W-1:0]  offY1,
  output logic [W-1:0]  offX1,
  output logic [W-1:0]  offY2,
  output logic [W-1:0]  offX2,
  output logic          readyA,
  output logic          readyC,
  output logic          loadDone,
  output logic [1:0]    loadIdx
);

  fol_strobe_t  strobe;
  logic         modeSerial;
  logic [W-1:0] offReg [4];

  fol_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .mrstN      (mrstN),
    .selHi      (selHi),
    .selEnN     (selEnN),
    .selData    (selData),
    .portEn     (portEn),
    .csN        (csN),
    .wrSel      (wrSel),
    .mbSel      (mbSel),
    .strobe     (strobe),
    .modeSerial (modeSerial),
    .done       (loadDone),
    .rdyA       (readyA),
    .rdyC       (readyC)
  );

  fol_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .mrstN      (mrstN),
    .strobe     (strobe),
    .modeSerial (modeSerial),
    .serBit     (selData),
    .busIn      (busIn),
    .offReg     (offReg)
  );

  assign offY1   = offReg[0];
  assign offX1   = offReg[1];
  assign offY2   = offReg[2];
  assign offX2   = offReg[3];
  assign loadIdx = strobe.idx;

endmodule

// File: rtl/fol_checker.sv
module fol_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         mrstN,
  input logic         portEn,
  input logic         selEnN,
  input logic [W-1:0] offY1,
  input logic [W-1:0] offX1,
  input logic [W-1:0] offY2,
  input logic [W-1:0] offX2,
  input logic         readyA,
  input logic         readyC,
  input logic         loadDone,
  input logic [1:0]   loadIdx
);

  p_ready_waits_done_r7: assert property (@(posedge clk) disable iff (!mrstN)
    !loadDone |-> (!readyA && !readyC));

  p_ready_pair_r7: assert property (@(posedge clk) disable iff (!mrstN)
    readyA == readyC);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!mrstN)
    loadDone |=> loadDone);

  p_offsets_frozen_r8: assert property (@(posedge clk) disable iff (!mrstN)
    loadDone |=> ($stable(offY1) && $stable(offX1) && $stable(offY2) && $stable(offX2)));

  p_idx_steps_by_one_r4: assert property (@(posedge clk) disable iff (!mrstN)
    (loadIdx != $past(loadIdx)) |-> (loadIdx == ($past(loadIdx) + 2'd1)));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!mrstN)
    (!portEn && selEnN) |=> ($stable(loadIdx) && $stable(loadDone) && $stable(offY1)
                             && $stable(offX1) && $stable(offY2) && $stable(offX2)));

endmodule

bind flag_offset_loader fol_checker #(.W(W)) i_fol_checker (
  .clk      (clk),
  .mrstN    (mrstN),
  .portEn   (portEn),
  .selEnN   (selEnN),
  .offY1    (offY1),
  .offX1    (offX1),
  .offY2    (offY2),
  .offX2    (offX2),
  .readyA   (readyA),
  .readyC   (readyC),
  .loadDone (loadDone),
  .loadIdx  (loadIdx)
);

// File: tb/test_flag_offset_loader.sv
`timescale 1ns/1ps
module test_flag_offset_loader;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic mrstN, selHi, selEnN, selData, portEn, csN, wrSel, mbSel;
  logic [W-1:0] busIn;
  logic [W-1:0] offY1, offX1, offY2, offX2;
  logic readyA, readyC, loadDone;
  logic [1:0] loadIdx;

  int checks = 0;
  int errors = 0;

  flag_offset_loader #(.W(W)) i_flag_offset_loader (
    .clk(clk), .mrstN(mrstN), .selHi(selHi), .selEnN(selEnN), .selData(selData),
    .portEn(portEn), .csN(csN), .wrSel(wrSel), .mbSel(mbSel), .busIn(busIn),
    .offY1(offY1), .offX1(offX1), .offY2(offY2), .offX2(offX2),
    .readyA(readyA), .readyC(readyC), .loadDone(loadDone), .loadIdx(loadIdx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input int seed);
    return W'(32'hA5C3 ^ (k * 32'h1F35) ^ seed);
  endfunction

  function automatic logic [W-1:0] offAt(input int i);
    case (i)
      0: return offY1;
      1: return offX1;
      2: return offY2;
      default: return offX2;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    portEn = 0; csN = 1; wrSel = 0; mbSel = 0; selEnN = 1; selData = 0; busIn = '0;
  endtask

  task automatic parWrite(input logic [W-1:0] v);
    portEn = 1; csN = 0; wrSel = 1; mbSel = 0; busIn = v;
  endtask

  task automatic doReset(input logic h, input logic e, input logic d);
    idle();
    selHi = h; selEnN = e; selData = d; mrstN = 0;
    tick(); tick();
    mrstN = 1;
    idle();
    tick();
  endtask

  task automatic checkCleared(input string req);
    chk({req, " done"}, loadDone, 0);
    chk({req, " readyA"}, readyA, 0);
    chk({req, " readyC"}, readyC, 0);
    chk({req, " idx"}, loadIdx, 0);
    for (int i = 0; i < 4; i++) chk({req, " offset"}, offAt(i), 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end

  initial begin
    logic [W-1:0] saved [4];
    logic [W-1:0] v;
    mrstN = 0; selHi = 0;
    idle();
    tick();

    // ---------------- parallel mode ----------------
    doReset(1, 0, 0);
    checkCleared("R1 reset");
    selHi = 0;  // R2: mode pins changed after reset must not matter
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 16; c++) begin
        if (c == 5) continue;  // portEn=1 csN=0 wrSel=1 mbSel=0 is the only accept
        portEn = c[0]; csN = c[1]; wrSel = c[2]; mbSel = c[3];
        busIn = W'(c * 32'h0777);
        selEnN = c[0]; selData = c[1];  // R9 serial pins toggle in parallel mode
        tick();
        chk("R3 unqualified write ignored idx", loadIdx, k);
        chk("R3 unqualified write ignored value", offAt(k), 0);
      end
      idle();
      parWrite(pat(k, 0));
      tick();
      idle();
      chk("R4 parallel value in order", offAt(k), pat(k, 0));
      chk("R4 idx advance", loadIdx, (k < 3) ? k + 1 : 3);
      if (k < 3) chk("R4 next register untouched", offAt(k + 1), 0);
      chk("R7 readyA", readyA, (k == 3));
      chk("R7 readyC", readyC, (k == 3));
      chk("R2 parallel mode kept", loadDone, (k == 3));
      tick();
      chk("R6 idle cycle holds idx", loadIdx, (k < 3) ? k + 1 : 3);
    end
    for (int i = 0; i < 3; i++) begin
      parWrite(W'(32'h5A5A + i));
      tick();
    end
    idle();
    for (int i = 0; i < 4; i++) chk("R8 frozen after done (parallel)", offAt(i), pat(i, 0));
    chk("R8 done stays", loadDone, 1);

    // ---------------- serial mode via selHi=0 ----------------
    doReset(0, 1, 1);
    checkCleared("R1 reset after load");
    parWrite(W'(32'h1234));
    tick();
    idle();
    chk("R9 parallel ignored in serial idx", loadIdx, 0);
    chk("R9 parallel ignored in serial value", offY1, 0);
    for (int k = 0; k < 4; k++) begin
      v = pat(k, 32'h3C3C);
      for (int b = W - 1; b >= 0; b--) begin
        if (b % 3 == 0) begin
          selEnN = 1; selData = ~v[b];
          parWrite(W'(32'hFFFF));
          tick();
          idle();
          chk("R6 gap holds idx (serial)", loadIdx, k);
        end
        selEnN = 0; selData = v[b];
        tick();
        idle();
        if (b == W / 2) begin
          chk("R5 word not stored early", offAt(k), 0);
          chk("R5 idx during word", loadIdx, k);
        end
      end
      chk("R5 serial word msb first", offAt(k), v);
      chk("R4 serial idx advance", loadIdx, (k < 3) ? k + 1 : 3);
      chk("R7 ready flags", {readyA, readyC}, (k == 3) ? 2'b11 : 2'b00);
    end
    for (int i = 0; i < 4; i++) saved[i] = offAt(i);
    for (int b = 0; b < 20; b++) begin
      selEnN = 0; selData = b[0];
      tick();
    end
    idle();
    for (int i = 0; i < 4; i++) chk("R8 frozen after done (serial)", offAt(i), saved[i]);
    chk("R8 done stays (serial)", loadDone, 1);

    // ---------------- serial via other select combination ----------------
    doReset(1, 1, 0);
    checkCleared("R1 reset again");
    v = pat(7, 32'h0F0F);
    for (int b = W - 1; b >= 0; b--) begin
      selEnN = 0; selData = v[b];
      tick();
    end
    idle();
    chk("R2 selHi=1 selEnN=1 gives serial", offY1, v);
    chk("R2 serial idx", loadIdx, 1);

    // ---------------- reset mid-load ----------------
    doReset(1, 0, 0);
    parWrite(W'(32'h0BAD));
    tick();
    idle();
    chk("R3 accepted after reset", offY1, W'(32'h0BAD));
    doReset(1, 0, 0);
    checkCleared("R1 reset mid-load");

    summary();
  end
endmodule